// File: doc/BRIEF.md
# Flash Operation Sequencer

This block is the control side of an embedded non-volatile memory. Software starts one operation at a time by writing a single command bit into a control word over a 32-bit register bus. The operations are page erase, whole-array erase, program, reference-cell erase and trim recall. The block then holds a busy flag for a number of clock cycles taken from programmable timing fields. While busy, it drives one abstract strobe and a latched target address toward the array-side port.

When the operation finishes, busy drops and the command bit clears itself. A pass/fail indication returned by the array is folded into a sticky write-error flag. Software clears that flag by writing a one to it. A command is refused, with the error flag set, if the write-protect bit is set in the same control write or if the write holds more than one command bit. Software finds out that an operation has finished by polling the busy flag.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset every register reads zero (control, the three timing words, address, status), and all array strobes and `arr_addr` are low.
- R2: The timing and address registers read back masked to their fields. Offset 0x04 holds the read wait count [5:0] and the hold-off count [31:16]. Offset 0x08 holds the erase duration [23:0]. Offset 0x0C holds the program duration [15:0], the tail count [23:16] and the recall duration [27:24]. Offset 0x20 holds an address of `ADDR_W` bits.
- R3: The control word is at offset 0x00: bit 1 is write-protect, bit 3 whole erase, bit 4 page erase, bit 5 program, bit 6 reference-cell erase and bit 7 recall. A write with exactly one command bit and bit 1 clear, made while idle, sets busy (status at 0x2C, bit 0) from the following cycle. The matching command bit then reads back as set.
- R4: Busy stays high for D+T cycles, and for at least 1 cycle. D is the erase duration for the three erase kinds, the program duration for program, and the recall duration for recall. T is the tail count.
- R5: When the operation ends, busy falls, the command bit reads back as zero and all strobes drop.
- R6: `arr_addr` is latched at the start. Page erase drives the address register with its low log2(`PAGE_BYTES`) bits zeroed. Program drives the full address. Whole erase, reference-cell erase and recall drive zero.
- R7: A command write that has bit 1 set sets the write error (status bit 1), and busy never rises.
- R8: A control write with two or more command bits sets the write error and starts nothing.
- R9: While busy, command bits in control writes are ignored: the running operation, its strobe, its address and its end cycle are unchanged, and no error is raised.
- R10: The write error is cleared by writing status with bit 1 set. Writing status with bit 1 clear leaves it unchanged.
- R11: If `arr_fail` is high in the last busy cycle, the write error is set when the operation ends.
- R12: At most one of `arr_erase`, `arr_prog` and `arr_recall` is high, and only while busy. `arr_whole` (whole erase) and `arr_refcell` (reference-cell erase) each rise only together with `arr_erase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| arr_erase | output | 1 | Erase in progress (any kind) |
| arr_prog | output | 1 | Program in progress |
| arr_recall | output | 1 | Trim recall in progress |
| arr_whole | output | 1 | Erase covers the whole array |
| arr_refcell | output | 1 | Erase targets the reference cell |
| arr_addr | output | ADDR_W | Latched target address |
| arr_fail | input | 1 | Array reports failure of the running operation |

## Verification
The hardest situation to reach from the ports is a control write that lands in the middle of a running operation. Several such writes are needed: a valid command, a multi-bit command, and an address change. The stimulus starts a long page erase and then issues three back-to-back writes in the following cycles. It counts the remaining busy cycles to show that the end cycle did not move, and it confirms that the strobe, the latched address and the error flag stayed untouched. The zero-length case (both durations zero) and a failure reported in the final busy cycle are covered by table rows.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_TIM0 = 8'h04;
   localparam logic [7:0] OFS_TIM1 = 8'h08;
   localparam logic [7:0] OFS_TIM2 = 8'h0C;
   localparam logic [7:0] OFS_ADDR = 8'h20;
   localparam logic [7:0] OFS_STAT = 8'h2C;

   localparam int CMD_LSB = 3;
   localparam int CMD_N   = 5;
   localparam int WP_BIT  = 1;

   typedef enum logic [2:0] {
      OP_NONE, OP_WHOLE, OP_PAGE, OP_PROG, OP_REF, OP_RECALL
   } op_e;

   // command bit index (relative to CMD_LSB) to operation
   function automatic op_e idx_to_op(input int idx);
      case (idx)
         0:       return OP_WHOLE;
         1:       return OP_PAGE;
         2:       return OP_PROG;
         3:       return OP_REF;
         4:       return OP_RECALL;
         default: return OP_NONE;
      endcase
   endfunction
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
   import flash_seq_pkg::*;
(
   input  logic [CMD_N-1:0] cmd,
   input  logic             wp,
   output op_e              op,
   output logic             any,
   output logic             bad
);
   logic [CMD_N-1:0][2:0] op_term;

   genvar g;
   generate
      for (g = 0; g < CMD_N; g++) begin : g_term
         assign op_term[g] = cmd[g] ? 3'(idx_to_op(g)) : 3'd0;
      end
   endgenerate

   always_comb begin
      logic [2:0] acc;
      acc = '0;
      for (int i = 0; i < CMD_N; i++) acc = acc | op_term[i];
      any = |cmd;
      bad = any && (wp || ($countones(cmd) > 1));
      op  = (any && !bad) ? op_e'(acc) : OP_NONE;
   end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
   parameter int CNT_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (load) begin
         busy <= 1'b1;
         cnt  <= (load_val == '0) ? '0 : load_val - 1'b1;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int ERASE_W = 24,
   parameter int PROG_W  = 16,
   parameter int HOLD_W  = 8,
   parameter int SETUP_W = 4,
   parameter int WS_W    = 6,
   parameter int NVH_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         wr_ofs,
   input  logic [31:0]        wdata,
   output logic               wp,
   output logic [WS_W-1:0]    ws,
   output logic [NVH_W-1:0]   nvh,
   output logic [ERASE_W-1:0] erase_cyc,
   output logic [PROG_W-1:0]  prog_cyc,
   output logic [HOLD_W-1:0]  hold_cyc,
   output logic [SETUP_W-1:0] setup_cyc,
   output logic [ADDR_W-1:0]  addr
);
   generate
      if (ERASE_W > 24 || PROG_W > 16 || HOLD_W > 8 || SETUP_W > 4)
         $error("timing field wider than its slot");
      if (WS_W > 6 || NVH_W > 16 || ADDR_W > 32)
         $error("register field wider than its slot");
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp        <= 1'b0;
         ws        <= '0;
         nvh       <= '0;
         erase_cyc <= '0;
         prog_cyc  <= '0;
         hold_cyc  <= '0;
         setup_cyc <= '0;
         addr      <= '0;
      end else if (wr_en) begin
         case (wr_ofs)
            OFS_CTRL: wp <= wdata[WP_BIT];
            OFS_TIM0: begin
               ws  <= wdata[0 +: WS_W];
               nvh <= wdata[16 +: NVH_W];
            end
            OFS_TIM1: erase_cyc <= wdata[0 +: ERASE_W];
            OFS_TIM2: begin
               prog_cyc  <= wdata[0 +: PROG_W];
               hold_cyc  <= wdata[16 +: HOLD_W];
               setup_cyc <= wdata[24 +: SETUP_W];
            end
            OFS_ADDR: addr <= wdata[0 +: ADDR_W];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PAGE_BYTES = 4096,
   parameter int ERASE_W    = 24,
   parameter int PROG_W     = 16,
   parameter int HOLD_W     = 8,
   parameter int SETUP_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              arr_erase,
   output logic              arr_prog,
   output logic              arr_recall,
   output logic              arr_whole,
   output logic              arr_refcell,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic              arr_fail
);
   localparam int DUR_W    = (ERASE_W > PROG_W) ? ERASE_W : PROG_W;
   localparam int CNT_W    = DUR_W + 1;
   localparam int PAGE_LSB = $clog2(PAGE_BYTES);
   localparam int WS_W     = 6;
   localparam int NVH_W    = 16;

   generate
      if ((1 << PAGE_LSB) != PAGE_BYTES) $error("PAGE_BYTES must be a power of two");
      if (PAGE_LSB >= ADDR_W)            $error("ADDR_W too small for one page");
      if (HOLD_W > DUR_W || SETUP_W > DUR_W) $error("counter too narrow");
   endgenerate

   logic               wp;
   logic [WS_W-1:0]    ws;
   logic [NVH_W-1:0]   nvh;
   logic [ERASE_W-1:0] erase_cyc;
   logic [PROG_W-1:0]  prog_cyc;
   logic [HOLD_W-1:0]  hold_cyc;
   logic [SETUP_W-1:0] setup_cyc;
   logic [ADDR_W-1:0]  addr_reg;

   flash_seq_regs #(
      .ADDR_W(ADDR_W), .ERASE_W(ERASE_W), .PROG_W(PROG_W),
      .HOLD_W(HOLD_W), .SETUP_W(SETUP_W), .WS_W(WS_W), .NVH_W(NVH_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_ofs(bus_addr),
      .wdata(bus_wdata), .wp(wp), .ws(ws), .nvh(nvh),
      .erase_cyc(erase_cyc), .prog_cyc(prog_cyc), .hold_cyc(hold_cyc),
      .setup_cyc(setup_cyc), .addr(addr_reg)
   );

   op_e  op_new;
   logic cmd_any, cmd_bad;

   flash_seq_decode i_dec (
      .cmd(bus_wdata[CMD_LSB +: CMD_N]), .wp(bus_wdata[WP_BIT]),
      .op(op_new), .any(cmd_any), .bad(cmd_bad)
   );

   logic             busy, done, start, reject, ctrl_wr, stat_wr;
   logic [CNT_W-1:0] dur_sel, load_val;

   assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
   assign stat_wr = bus_wr && (bus_addr == OFS_STAT);
   assign start   = ctrl_wr && !busy && cmd_any && !cmd_bad;
   assign reject  = ctrl_wr && !busy && cmd_bad;

   always_comb begin
      case (op_new)
         OP_WHOLE, OP_PAGE, OP_REF: dur_sel = CNT_W'(erase_cyc);
         OP_PROG:                   dur_sel = CNT_W'(prog_cyc);
         OP_RECALL:                 dur_sel = CNT_W'(setup_cyc);
         default:                   dur_sel = '0;
      endcase
      load_val = dur_sel + CNT_W'(hold_cyc);
   end

   flash_seq_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(load_val),
      .busy(busy), .done(done)
   );

   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              werr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_NONE;
         addr_q <= '0;
      end else if (start) begin
         op_q <= op_new;
         case (op_new)
            OP_PAGE: addr_q <= {addr_reg[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
            OP_PROG: addr_q <= addr_reg;
            default: addr_q <= '0;
         endcase
      end else if (done) begin
         op_q   <= OP_NONE;
         addr_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          werr_q <= 1'b0;
      else if (reject || (done && arr_fail)) werr_q <= 1'b1;
      else if (stat_wr && bus_wdata[1])    werr_q <= 1'b0;
   end

   assign arr_erase   = (op_q == OP_WHOLE) || (op_q == OP_PAGE) || (op_q == OP_REF);
   assign arr_prog    = (op_q == OP_PROG);
   assign arr_recall  = (op_q == OP_RECALL);
   assign arr_whole   = (op_q == OP_WHOLE);
   assign arr_refcell = (op_q == OP_REF);
   assign arr_addr    = addr_q;

   logic [CMD_N-1:0] cmd_rb;
   genvar g;
   generate
      for (g = 0; g < CMD_N; g++) begin : g_rb
         assign cmd_rb[g] = (op_q == idx_to_op(g));
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[CMD_LSB +: CMD_N] = cmd_rb;
            bus_rdata[WP_BIT]           = wp;
         end
         OFS_TIM0: begin
            bus_rdata[0 +: WS_W]   = ws;
            bus_rdata[16 +: NVH_W] = nvh;
         end
         OFS_TIM1: bus_rdata[0 +: ERASE_W] = erase_cyc;
         OFS_TIM2: begin
            bus_rdata[0 +: PROG_W]   = prog_cyc;
            bus_rdata[16 +: HOLD_W]  = hold_cyc;
            bus_rdata[24 +: SETUP_W] = setup_cyc;
         end
         OFS_ADDR: bus_rdata[0 +: ADDR_W] = addr_reg;
         OFS_STAT: bus_rdata[1:0] = {werr_q, busy};
         default: ;
      endcase
   end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
   parameter int ADDR_W   = 24,
   parameter int PAGE_LSB = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [7:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic              werr,
   input logic              arr_erase,
   input logic              arr_prog,
   input logic              arr_recall,
   input logic              arr_whole,
   input logic              arr_refcell,
   input logic [ADDR_W-1:0] arr_addr
);
   a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({arr_erase, arr_prog, arr_recall}));

   a_r12_sub_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_whole || arr_refcell) |-> (arr_erase && !(arr_whole && arr_refcell)));

   a_r3_strobe_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_erase || arr_prog || arr_recall) == busy);

   a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_erase && !arr_whole && !arr_refcell) |-> (arr_addr[PAGE_LSB-1:0] == '0));

   a_r7_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h00 && !busy && bus_wdata[1] && (|bus_wdata[7:3]))
      |=> (werr && !busy));

   a_r8_multi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h00 && !busy && ($countones(bus_wdata[7:3]) > 1))
      |=> (werr && !busy));

   a_r9_op_steady: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable({arr_erase, arr_prog, arr_recall, arr_whole, arr_refcell, arr_addr})));

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h2C && bus_wdata[1] && !busy) |=> !werr);
endmodule

bind flash_seq_ctrl flash_seq_chk #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .werr(werr_q),
   .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_recall(arr_recall),
   .arr_whole(arr_whole), .arr_refcell(arr_refcell), .arr_addr(arr_addr)
);

// File: tb/test_flash_seq_ctrl.sv
`timescale 1ns/1ps
module test_flash_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        arr_erase, arr_prog, arr_recall, arr_whole, arr_refcell;
   logic [23:0] arr_addr;
   logic        arr_fail = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   flash_seq_ctrl i_flash_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_erase(arr_erase),
      .arr_prog(arr_prog), .arr_recall(arr_recall), .arr_whole(arr_whole),
      .arr_refcell(arr_refcell), .arr_addr(arr_addr), .arr_fail(arr_fail)
   );

   // cmd bits: [0]=whole [1]=page [2]=prog [3]=ref [4]=recall (control bits 3..7)
   // str: {erase, prog, recall, whole, refcell}
   typedef struct packed {
      logic [4:0]  cmd;
      logic        wp;
      logic        fail;
      logic [23:0] er;
      logic [15:0] pg;
      logic [7:0]  hd;
      logic [3:0]  st;
      logic [23:0] ad;
      logic [15:0] n;
      logic [4:0]  str;
      logic [23:0] xad;
      logic        xwerr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{5'b00001, 1'b0, 1'b0, 24'd5, 16'd0, 8'd2,   4'd0,  24'h000000, 16'd7,   5'b10010, 24'h000000, 1'b0},
      '{5'b00010, 1'b0, 1'b0, 24'd3, 16'd0, 8'd1,   4'd0,  24'h012345, 16'd4,   5'b10000, 24'h012000, 1'b0},
      '{5'b00100, 1'b0, 1'b0, 24'd9, 16'd6, 8'd0,   4'd0,  24'h012345, 16'd6,   5'b01000, 24'h012345, 1'b0},
      '{5'b01000, 1'b0, 1'b0, 24'd2, 16'd0, 8'd3,   4'd0,  24'h0ABCDE, 16'd5,   5'b10001, 24'h000000, 1'b0},
      '{5'b10000, 1'b0, 1'b0, 24'd9, 16'd9, 8'd2,   4'd4,  24'h0ABCDE, 16'd6,   5'b00100, 24'h000000, 1'b0},
      '{5'b00100, 1'b0, 1'b0, 24'd0, 16'd0, 8'd0,   4'd0,  24'h000010, 16'd1,   5'b01000, 24'h000010, 1'b0},
      '{5'b00100, 1'b1, 1'b0, 24'd4, 16'd4, 8'd0,   4'd0,  24'h000010, 16'd0,   5'b00000, 24'h000000, 1'b1},
      '{5'b00011, 1'b0, 1'b0, 24'd4, 16'd4, 8'd0,   4'd0,  24'h000010, 16'd0,   5'b00000, 24'h000000, 1'b1},
      '{5'b00010, 1'b0, 1'b1, 24'd2, 16'd0, 8'd0,   4'd0,  24'h001FFF, 16'd2,   5'b10000, 24'h001000, 1'b1},
      '{5'b10000, 1'b0, 1'b0, 24'd0, 16'd0, 8'd255, 4'd15, 24'h000000, 16'd270, 5'b00100, 24'h000000, 1'b0}
   };
   string VTAG [NV] = '{"R4 whole", "R6 page", "R6 prog", "R4 ref", "R4 recall",
                        "R4 zero", "R7 protect", "R8 multi", "R11 fail", "R4 long"};

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic count_busy(output int n);
      logic [31:0] s;
      n = 0;
      rd(8'h2C, s);
      while (s[0] && n < 2000) begin
         n++;
         @(posedge clk);
         #1;
         rd(8'h2C, s);
      end
   endtask

   function automatic logic [4:0] strobes();
      return {arr_erase, arr_prog, arr_recall, arr_whole, arr_refcell};
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(8'h00, r); check("R1 control", r, 0);
      rd(8'h08, r); check("R1 tim1", r, 0);
      rd(8'h2C, r); check("R1 status", r, 0);
      check("R1 strobes", {27'd0, strobes()}, 0);

      // R2: field masking
      wr(8'h04, 32'hFFFFFFFF); rd(8'h04, r); check("R2 tim0", r, 32'hFFFF003F);
      wr(8'h08, 32'hFFFFFFFF); rd(8'h08, r); check("R2 tim1", r, 32'h00FFFFFF);
      wr(8'h0C, 32'hFFFFFFFF); rd(8'h0C, r); check("R2 tim2", r, 32'h0FFFFFFF);
      wr(8'h20, 32'hFFFFFFFF); rd(8'h20, r); check("R2 addr", r, 32'h00FFFFFF);

      // table of operations
      for (int i = 0; i < NV; i++) begin
         wr(8'h08, 32'(VEC[i].er));
         wr(8'h0C, {4'd0, VEC[i].st, VEC[i].hd, VEC[i].pg});
         wr(8'h20, 32'(VEC[i].ad));
         wr(8'h2C, 32'h2);
         arr_fail = VEC[i].fail;
         wr(8'h00, {24'd0, VEC[i].cmd, 1'b0, VEC[i].wp, 1'b0});
         check({VTAG[i], " R12 strobes"}, {27'd0, strobes()}, {27'd0, VEC[i].str});
         check({VTAG[i], " R6 addr"}, 32'(arr_addr), 32'(VEC[i].xad));
         if (VEC[i].n != 0) begin
            rd(8'h00, r);
            check({VTAG[i], " R3 cmd readback"}, {27'd0, r[7:3]}, {27'd0, VEC[i].cmd});
         end
         count_busy(n);
         check({VTAG[i], " R4 busy cycles"}, n, 32'(VEC[i].n));
         arr_fail = 1'b0;
         rd(8'h2C, r); check({VTAG[i], " R11 werr"}, {31'd0, r[1]}, {31'd0, VEC[i].xwerr});
         rd(8'h00, r); check({VTAG[i], " R5 cmd cleared"}, {27'd0, r[7:3]}, 0);
         check({VTAG[i], " R5 strobes low"}, {27'd0, strobes()}, 0);
         wr(8'h00, 32'h0);
      end

      // R9: writes during a running page erase
      wr(8'h08, 32'd10); wr(8'h0C, 32'd0); wr(8'h20, 32'h3456); wr(8'h2C, 32'h2);
      wr(8'h00, 32'h10);
      wr(8'h00, 32'h20);
      wr(8'h00, 32'h18);
      wr(8'h20, 32'h7777);
      check("R9 strobe kept", {27'd0, strobes()}, {27'd0, 5'b10000});
      check("R9 addr kept", 32'(arr_addr), 32'h3000);
      count_busy(n);
      check("R9 end cycle unchanged", n, 7);
      rd(8'h2C, r); check("R9 no error", r, 0);

      // R10: write-one-to-clear
      wr(8'h00, 32'h18);
      rd(8'h2C, r); check("R8 error set", r, 32'h2);
      wr(8'h2C, 32'h1);
      rd(8'h2C, r); check("R10 zero keeps", r, 32'h2);
      wr(8'h2C, 32'h2);
      rd(8'h2C, r); check("R10 one clears", r, 0);

      // R1: reset during an operation
      wr(8'h08, 32'd100);
      wr(8'h00, 32'h08);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1;
      rd(8'h2C, r); check("R1 status after reset", r, 0);
      rd(8'h08, r); check("R1 tim1 after reset", r, 0);
      check("R1 strobes after reset", {27'd0, strobes()}, 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule